// File: doc/BRIEF.md
# Reference Divider and Phase-Frequency Detector

This block sits in the digital part of a frequency synthesizer. It divides a crystal reference clock by one of three ratios, picked by a two-bit register field, and so produces a comparison tick that lasts one clock cycle. It also takes a feedback clock from the synthesizer's main divider and detects its rising edges. A two-flop phase-frequency detector weighs the comparison tick against each feedback edge. The detector raises a pump-up enable when the reference leads and a pump-down enable when the feedback leads. When both events have been seen, it clears the two flops together.

Three control bits come from the control register. The first turns the pump off, forcing both enables low while the detector state is kept. The second selects the high or low pump current. The third switches off the tuning-voltage output. The analog charge pump and the loop filter are not in this block. They appear here only as the enable and select levels they would consume.

The two ratio bits form the field `rsel`, with `rsel[1]` as the high bit and `rsel[0]` as the low bit. When the low bit is 0, the divider uses its middle ratio and ignores the high bit. A new ratio is loaded only at the terminal count, so a period that is already running is never cut short.

Top module: `refdiv_pfd`

## Requirements
- R1: During reset and immediately after it, `cmp_tick`, `pump_up` and `pump_dn` are 0. The ratio in force after reset is 160, so the first tick appears in the 160th clock cycle after reset is released.
- R2: With `rsel` = 2'b01, the tick repeats every 256 clock cycles.
- R3: With `rsel` = 2'b11, the tick repeats every 128 clock cycles.
- R4: With `rsel[0]` = 0, the tick repeats every 160 clock cycles, for both `rsel` = 2'b00 and `rsel` = 2'b10.
- R5: `cmp_tick` is high for exactly one clock cycle per period.
- R6: A change of `rsel` in the middle of a period leaves the length of that period unchanged. The new ratio governs the following period.
- R7: A tick that comes while the detector is idle makes `pump_up` 1 from the next cycle on. It stays 1 until a rising edge of `fb_in` is sampled, and both enables are 0 in the cycle after that sample.
- R8: A rising edge of `fb_in` that comes while the detector is idle makes `pump_dn` 1 from the next cycle on. It stays 1 until the next tick, and both enables are 0 in the cycle after the tick.
- R9: When a tick and a sampled rising edge of `fb_in` fall in the same cycle on an idle detector, neither `pump_up` nor `pump_dn` is raised. `pump_up` and `pump_dn` are never 1 together.
- R10: `pump_off` = 1 forces `pump_up` and `pump_dn` to 0 in the same cycle. The detector state is kept, so the held enable reappears once `pump_off` returns to 0.
- R11: `i_high` follows `cp_hi` and `varicap_off` follows `vt_off` combinationally, independently of `pump_off`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fb_in | input | 1 | Feedback clock from the main divider, sampled on `clk` |
| rsel | input | 2 | Reference ratio select: x0 gives 160, 01 gives 256, 11 gives 128 |
| cp_hi | input | 1 | Pump current select bit, 1 selects high current |
| pump_off | input | 1 | Pump disable bit |
| vt_off | input | 1 | Tuning-voltage output disable bit |
| cmp_tick | output | 1 | One-cycle comparison tick |
| pump_up | output | 1 | Charge-up enable |
| pump_dn | output | 1 | Charge-down enable |
| i_high | output | 1 | High-current select level |
| pump_dis | output | 1 | Pump disabled level |
| varicap_off | output | 1 | Tuning-voltage output off level |

## Verification
The divider's terminal tick and a feedback rising edge can arrive in the same cycle, so each would set one detector flop while the clearing path acts on both. The bench provokes this case on an idle detector. It waits until it sees the tick high between edges, then raises `fb_in` at that point, so that the next edge samples both events. The case is judged at the ports: neither enable may rise in the cycle that follows, nor in the cycles after it. A second overlap is also checked: a pump disable applied while an enable is pending must hide that enable at once and must not lose it.

// File: rtl/refdiv_pfd.sv
module refdiv_pfd #(
  parameter int RATIO_01 = 256,
  parameter int RATIO_11 = 128,
  parameter int RATIO_X0 = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_in,
  input  logic [1:0] rsel,
  input  logic       cp_hi,
  input  logic       pump_off,
  input  logic       vt_off,
  output logic       cmp_tick,
  output logic       pump_up,
  output logic       pump_dn,
  output logic       i_high,
  output logic       pump_dis,
  output logic       varicap_off
);
  localparam int RMAX = (RATIO_01 > RATIO_11) ?
                        ((RATIO_01 > RATIO_X0) ? RATIO_01 : RATIO_X0) :
                        ((RATIO_11 > RATIO_X0) ? RATIO_11 : RATIO_X0);
  localparam int CW = $clog2(RMAX + 1);

  logic [CW-1:0] cnt, lim, nxt_lim;
  logic          tick_q, term;
  logic          fb_d, fb_rise, up_q, dn_q, set_up, set_dn;

  assign nxt_lim = !rsel[0] ? CW'(RATIO_X0) : (rsel[1] ? CW'(RATIO_11) : CW'(RATIO_01));
  assign term    = (cnt == lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      lim    <= CW'(RATIO_X0);
      tick_q <= 1'b0;
    end else begin
      tick_q <= term;
      if (term) begin
        cnt <= '0;
        lim <= nxt_lim;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end

  assign fb_rise = fb_in & ~fb_d;
  assign set_up  = up_q | tick_q;
  assign set_dn  = dn_q | fb_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fb_d <= 1'b0;
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      fb_d <= fb_in;
      up_q <= set_up & ~set_dn;
      dn_q <= set_dn & ~set_up;
    end

  assign cmp_tick    = tick_q;
  assign pump_up     = up_q & ~pump_off;
  assign pump_dn     = dn_q & ~pump_off;
  assign pump_dis    = pump_off;
  assign i_high      = cp_hi;
  assign varicap_off = vt_off;
endmodule

// File: rtl/refdiv_pfd_chk.sv
module refdiv_pfd_chk (
  input logic clk,
  input logic rst_n,
  input logic fb_in,
  input logic pump_off,
  input logic cmp_tick,
  input logic pump_up,
  input logic pump_dn
);
  logic fb_prev, fb_edge;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fb_prev <= 1'b0;
    else        fb_prev <= fb_in;
  assign fb_edge = fb_in & ~fb_prev;

  p_tick_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_tick |=> !cmp_tick);

  p_pump_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pump_off |-> (!pump_up && !pump_dn));

  p_never_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  p_up_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_tick && !fb_edge && !pump_dn && !pump_off) |=> (pump_up || pump_off));

  p_up_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && !fb_edge) |=> (pump_up || pump_off));

  p_coincide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_tick && fb_edge && !pump_up && !pump_dn && !pump_off) |=> (!pump_up && !pump_dn));
endmodule

bind refdiv_pfd refdiv_pfd_chk i_chk (
  .clk(clk), .rst_n(rst_n), .fb_in(fb_in), .pump_off(pump_off),
  .cmp_tick(cmp_tick), .pump_up(pump_up), .pump_dn(pump_dn)
);

// File: tb/test_refdiv_pfd.sv
`timescale 1ns/1ps
module test_refdiv_pfd;
  logic clk = 1'b0, rst_n = 1'b0, fb_in = 1'b0, cp_hi = 1'b0, pump_off = 1'b0, vt_off = 1'b0;
  logic [1:0] rsel = 2'b00;
  logic cmp_tick, pump_up, pump_dn, i_high, pump_dis, varicap_off;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  refdiv_pfd i_refdiv_pfd (
    .clk(clk), .rst_n(rst_n), .fb_in(fb_in), .rsel(rsel), .cp_hi(cp_hi),
    .pump_off(pump_off), .vt_off(vt_off), .cmp_tick(cmp_tick), .pump_up(pump_up),
    .pump_dn(pump_dn), .i_high(i_high), .pump_dis(pump_dis), .varicap_off(varicap_off)
  );

  // {rsel, period}
  localparam logic [10:0] VEC [4] = '{
    {2'b01, 9'd256}, {2'b11, 9'd128}, {2'b00, 9'd160}, {2'b10, 9'd160}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  // counts negedges until cmp_tick is seen high; returns the count
  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cmp_tick && n < 1000);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fb_in = 1'b0; pump_off = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int n;
    repeat (2) @(negedge clk);
    chk("R1 tick in reset", cmp_tick, 0);
    chk("R1 up in reset", pump_up, 0);
    chk("R1 dn in reset", pump_dn, 0);
    rsel = 2'b11;
    @(negedge clk);
    rst_n = 1'b1;
    wait_tick(n);
    chk("R1 first period", n, 160);

    // table walk: ratio set before the terminal edge, then one full period measured
    for (int i = 0; i < 4; i++) begin
      rsel = VEC[i][10:9];
      wait_tick(n);
      @(negedge clk);
      chk("R5 tick width", cmp_tick, 0);
      wait_tick(n);
      chk((VEC[i][8:0] == 9'd256) ? "R2 period" :
          (VEC[i][8:0] == 9'd128) ? "R3 period" : "R4 period",
          n + 1, VEC[i][8:0]);
    end

    // R6: mid-period change
    rsel = 2'b01;
    wait_tick(n);
    wait_tick(n);
    repeat (10) @(negedge clk);
    rsel = 2'b11;
    wait_tick(n);
    chk("R6 old ratio kept", n + 10, 256);
    wait_tick(n);
    chk("R6 new ratio used", n, 128);

    // R7: reference leads
    do_reset();
    wait_tick(n);
    @(negedge clk);
    chk("R7 up set", pump_up, 1);
    chk("R7 dn idle", pump_dn, 0);
    repeat (5) @(negedge clk);
    chk("R7 up held", pump_up, 1);
    fb_in = 1'b1;
    @(negedge clk);
    chk("R7 up cleared", pump_up, 0);
    chk("R7 dn stays low", pump_dn, 0);
    repeat (3) @(negedge clk);
    fb_in = 1'b0;

    // R8: feedback leads
    repeat (3) @(negedge clk);
    fb_in = 1'b1;
    @(negedge clk);
    chk("R8 dn set", pump_dn, 1);
    chk("R8 up idle", pump_up, 0);
    fb_in = 1'b0;
    wait_tick(n);
    chk("R8 dn held to tick", pump_dn, 1);
    @(negedge clk);
    chk("R8 dn cleared", pump_dn, 0);
    chk("R8 up stays low", pump_up, 0);

    // R9: tick and feedback edge in the same cycle
    wait_tick(n);
    @(negedge clk);
    fb_in = 1'b0;
    // state now has up pending; clear it with a feedback edge
    fb_in = 1'b1;
    @(negedge clk);
    fb_in = 1'b0;
    chk("R9 idle before", pump_up | pump_dn, 0);
    wait_tick(n);
    fb_in = 1'b1;
    @(negedge clk);
    chk("R9 no up", pump_up, 0);
    chk("R9 no dn", pump_dn, 0);
    repeat (4) @(negedge clk);
    chk("R9 still idle", pump_up | pump_dn, 0);
    fb_in = 1'b0;

    // R10: pump disable hides and keeps the pending enable
    wait_tick(n);
    @(negedge clk);
    chk("R10 up pending", pump_up, 1);
    pump_off = 1'b1;
    #1;
    chk("R10 up forced low", pump_up, 0);
    chk("R10 dis level", pump_dis, 1);
    repeat (3) @(negedge clk);
    chk("R10 up still low", pump_up, 0);
    pump_off = 1'b0;
    #1;
    chk("R10 up returns", pump_up, 1);

    // R11: pass-through levels
    pump_off = 1'b1; cp_hi = 1'b1; vt_off = 1'b1;
    #1;
    chk("R11 current select", i_high, 1);
    chk("R11 varicap off", varicap_off, 1);
    cp_hi = 1'b0; vt_off = 1'b0;
    #1;
    chk("R11 current low", i_high, 0);
    chk("R11 varicap on", varicap_off, 0);
    pump_off = 1'b0;

    @(negedge clk);
    finish_run();
  end
endmodule